// File: doc/BRIEF.md
# Crosspoint Switch Control Memory

This block keeps the on/off state of a 12-row by 8-column crosspoint array. There is one control bit per crosspoint, 96 in all. A host selects one cell with a row code and a column number, puts the wanted value on the data input and raises the strobe. The block decodes the selection and updates only that cell. It presents all 96 cell states as a flat vector of switch enables, which drive the analog switches elsewhere in the chip.

Everything runs in one clock domain. Strobe and data are sampled on every rising clock edge. A level-transparent latch is emulated this way: in every cycle where the strobe is sampled high, the addressed cell takes the current data value. Once the strobe is sampled low, the cell holds what it last took.

A small write controller follows the strobe phase through three named states:
- `ST_CLEAR` is held while reset is high and left on the first edge after reset falls.
- `ST_IDLE` means the strobe is low.
- `ST_OPEN` means the strobe is high and the latch is transparent.

The transitions are:
- CLEAR→IDLE and CLEAR→OPEN: leaving reset, according to the strobe.
- IDLE→OPEN: the strobe rises.
- OPEN→OPEN: the strobe stays high.
- OPEN→IDLE: the strobe falls, which is the capture point.
- IDLE→IDLE: the strobe stays low.

The reset input is active high and asynchronous. It clears every cell at once.

Top module: `xpt_ctrl_mem`

## Requirements
- R1: While `rst_i` is high, all 96 bits of `sw_en_o` are 0. The clear takes effect at once, without waiting for a clock edge.
- R2: Bit position in `sw_en_o` is `col_i*12 + row`. Row codes 0 to 5 map to rows 0 to 5, and row codes 8 to 13 map to rows 6 to 11.
- R3: A write with row code 6, 7, 14 or 15 leaves all 96 bits unchanged.
- R4: Data 1 turns the addressed bit on and data 0 turns it off. The new value appears after the rising edge at which `strobe_i` is sampled high.
- R5: While `strobe_i` stays high over several cycles, the addressed bit follows `data_i` in each of those cycles.
- R6: After `strobe_i` is sampled low, the addressed bit keeps the data value from the last cycle in which the strobe was sampled high. No bit changes while the strobe is low.
- R7: Any write changes at most one bit: the addressed one. The other 95 bits keep their state.
- R8: Reset wins over strobe. A strobe that is high while `rst_i` is high writes nothing.
- R9: Any number of bits may be on together, including a whole column or a whole row. The block enforces no exclusivity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Asynchronous active-high clear of all cells |
| strobe_i | input | 1 | Write strobe; addressed cell is transparent while high |
| data_i | input | 1 | Value written to the addressed cell (1 = switch on) |
| row_code_i | input | 4 | Row code; 0-5 and 8-13 are valid, the rest select nothing |
| col_i | input | 3 | Column number 0-7 |
| sw_en_o | output | 96 | Switch enables, bit `col*12+row` |

## Verification
Directed single writes go to codes 0, 8 and 13 in several columns. They separate a correct row map from one that ignores the gap between the two row banks. Writes to every hole code, with data 1, show whether a hole wrongly aliases onto a real row. A strobe held high while data toggles separates true transparency from edge-only capture. A strobe raised during reset checks priority. A seeded random mix of strobes, data, codes, columns and occasional resets is compared against a bench model on every cycle. It catches writes that leak to neighbouring cells and holds that drift.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
    localparam int ROWS      = 12;
    localparam int COLS      = 8;
    localparam int ROW_AW    = 4;
    localparam int COL_AW    = 3;
    localparam int BANK_ROWS = ROWS / 2;
    localparam int CELLS     = ROWS * COLS;
    localparam int IDX_W     = $clog2(CELLS);

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_IDLE  = 2'd1,
        ST_OPEN  = 2'd2
    } wr_state_e;
endpackage

// File: rtl/xpt_addr_decode.sv
module xpt_addr_decode
    import xpt_pkg::*;
#(
    parameter int N_ROWS  = ROWS,
    parameter int N_COLS  = COLS,
    parameter int RA_W    = ROW_AW,
    parameter int CA_W    = COL_AW,
    parameter int N_CELLS = N_ROWS * N_COLS,
    parameter int IX_W    = $clog2(N_CELLS)
) (
    input  logic [RA_W-1:0]    row_code_i,
    input  logic [CA_W-1:0]    col_i,
    output logic               hit_o,
    output logic [IX_W-1:0]    idx_o,
    output logic [N_CELLS-1:0] sel_o
);
    localparam int BANK = N_ROWS / 2;
    localparam int LO_W = RA_W - 1;

    logic [LO_W-1:0] low_bits;
    logic            bank_bit;
    logic [IX_W-1:0] row_num;

    assign low_bits = row_code_i[LO_W-1:0];
    assign bank_bit = row_code_i[RA_W-1];

    always_comb begin
        hit_o   = (int'(low_bits) < BANK) && (int'(col_i) < N_COLS);
        row_num = IX_W'(int'(low_bits) + (bank_bit ? BANK : 0));
        idx_o   = IX_W'(int'(col_i) * N_ROWS + int'(row_num));
    end

    for (genvar c = 0; c < N_COLS; c++) begin : g_col
        for (genvar r = 0; r < N_ROWS; r++) begin : g_row
            assign sel_o[c*N_ROWS + r] = hit_o && (int'(row_num) == r) && (int'(col_i) == c);
        end
    end

    always_comb begin
        assert ($onehot0(sel_o)) else $error("AST_SEL_ONEHOT"); // R7
        if (!hit_o) assert (sel_o == '0) else $error("AST_HOLE_SELECTS_NONE"); // R3
    end
endmodule

// File: rtl/xpt_wr_ctrl.sv
module xpt_wr_ctrl
    import xpt_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic strobe_i,
    output logic wr_en_o,
    output logic capture_o
);
    wr_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: state_d = strobe_i ? ST_OPEN : ST_IDLE;
            ST_IDLE:  state_d = strobe_i ? ST_OPEN : ST_IDLE;
            ST_OPEN:  state_d = strobe_i ? ST_OPEN : ST_IDLE;
            default:  state_d = ST_CLEAR;
        endcase
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) state_q <= ST_CLEAR;
        else       state_q <= state_d;
    end

    always_comb begin
        wr_en_o   = 1'b0;
        capture_o = 1'b0;
        unique case (state_q)
            ST_CLEAR: wr_en_o = strobe_i && !rst_i;
            ST_IDLE:  wr_en_o = strobe_i && !rst_i;
            ST_OPEN: begin
                wr_en_o   = strobe_i && !rst_i;
                capture_o = !strobe_i;
            end
            default: wr_en_o = 1'b0;
        endcase
    end

    AST_OPEN_AFTER_STROBE: assert property (@(posedge clk_i) disable iff (rst_i)
        strobe_i |=> (state_q == ST_OPEN)); // R5
    AST_IDLE_AFTER_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
        !strobe_i |=> (state_q == ST_IDLE)); // R6
endmodule

// File: rtl/xpt_cell_array.sv
module xpt_cell_array #(
    parameter int N_CELLS = xpt_pkg::CELLS
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               wr_en_i,
    input  logic               data_i,
    input  logic [N_CELLS-1:0] sel_i,
    output logic [N_CELLS-1:0] cell_o
);
    for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
        always_ff @(posedge clk_i or posedge rst_i) begin
            if (rst_i)                     cell_o[i] <= 1'b0;
            else if (wr_en_i && sel_i[i])  cell_o[i] <= data_i;
        end
    end

    AST_NO_WRITE_WITHOUT_EN: assert property (@(posedge clk_i) disable iff (rst_i)
        !wr_en_i |=> $stable(cell_o)); // R6
endmodule

// File: rtl/xpt_ctrl_mem.sv
module xpt_ctrl_mem
    import xpt_pkg::*;
#(
    parameter int N_ROWS = ROWS,
    parameter int N_COLS = COLS,
    parameter int RA_W   = ROW_AW,
    parameter int CA_W   = COL_AW
) (
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  logic                       strobe_i,
    input  logic                       data_i,
    input  logic [RA_W-1:0]            row_code_i,
    input  logic [CA_W-1:0]            col_i,
    output logic [N_ROWS*N_COLS-1:0]   sw_en_o
);
    localparam int N_CELLS = N_ROWS * N_COLS;
    localparam int IX_W    = $clog2(N_CELLS);

    logic               hit;
    logic [IX_W-1:0]    idx;
    logic [N_CELLS-1:0] sel;
    logic               wr_en;
    logic               capture;

    xpt_addr_decode #(
        .N_ROWS(N_ROWS), .N_COLS(N_COLS), .RA_W(RA_W), .CA_W(CA_W),
        .N_CELLS(N_CELLS), .IX_W(IX_W)
    ) u_dec (
        .row_code_i(row_code_i),
        .col_i     (col_i),
        .hit_o     (hit),
        .idx_o     (idx),
        .sel_o     (sel)
    );

    xpt_wr_ctrl u_ctl (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .strobe_i (strobe_i),
        .wr_en_o  (wr_en),
        .capture_o(capture)
    );

    xpt_cell_array #(.N_CELLS(N_CELLS)) u_cells (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .wr_en_i(wr_en),
        .data_i (data_i),
        .sel_i  (sel),
        .cell_o (sw_en_o)
    );

    AST_RESET_LEAVES_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |-> (sw_en_o == '0)); // R1
    AST_SINGLE_CELL_CHANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> ($countones(sw_en_o ^ $past(sw_en_o)) <= 1)); // R7
    AST_HOLE_NO_CHANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        !hit |=> $stable(sw_en_o)); // R3
    AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (rst_i)
        (strobe_i && hit) |=> (sw_en_o[$past(idx)] == $past(data_i))); // R4
    AST_HOLD_AFTER_CAPTURE: assert property (@(posedge clk_i) disable iff (rst_i)
        capture |=> $stable(sw_en_o)); // R6
endmodule

// File: tb/xpt_ctrl_mem_tb.sv
module xpt_ctrl_mem_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strobe = 1'b0;
    logic        data = 1'b0;
    logic [3:0]  row = 4'd0;
    logic [2:0]  col = 3'd0;
    logic [95:0] sw_en;
    logic [95:0] expv = '0;
    logic [95:0] snap;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    xpt_ctrl_mem u_dut (
        .clk_i(clk), .rst_i(rst), .strobe_i(strobe), .data_i(data),
        .row_code_i(row), .col_i(col), .sw_en_o(sw_en)
    );

    function automatic int row_of(input logic [3:0] code);
        if (code <= 4'd5) return int'(code);
        if (code >= 4'd8 && code <= 4'd13) return int'(code) - 2;
        return -1;
    endfunction

    task automatic check(input logic [95:0] got, input logic [95:0] want, input string req);
        n_chk++;
        if (got !== want) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, want);
        end
    endtask

    task automatic step(input logic s, input logic d, input logic r,
                        input logic [3:0] rc, input logic [2:0] c, input string req);
        @(negedge clk);
        strobe = s; data = d; rst = r; row = rc; col = c;
        if (r) expv = '0;
        @(posedge clk);
        if (!r && s && row_of(rc) >= 0) expv[int'(c)*12 + row_of(rc)] = d;
        #5;
        check(sw_en, expv, req);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        #3;
        check(sw_en, '0, "R1 reset state");
        step(1'b0, 1'b0, 1'b0, 4'd0, 3'd0, "R1 release");

        step(1'b1, 1'b1, 1'b0, 4'd0, 3'd0, "R4 on code0 col0");
        check(sw_en, 96'h1, "R2 bit0");
        step(1'b0, 1'b1, 1'b0, 4'd0, 3'd0, "R6 strobe low");
        step(1'b1, 1'b1, 1'b0, 4'd8, 3'd0, "R2 code8");
        check(sw_en, 96'h41, "R2 code8 is bit6");
        step(1'b1, 1'b1, 1'b0, 4'd13, 3'd7, "R2 code13 col7");
        check(96'(sw_en[95]), 96'h1, "R2 bit95");
        step(1'b0, 1'b0, 1'b0, 4'd13, 3'd7, "R6");
        step(1'b1, 1'b0, 1'b0, 4'd0, 3'd0, "R4 off");

        snap = sw_en;
        step(1'b1, 1'b1, 1'b0, 4'd6, 3'd1, "R3 code6");
        step(1'b1, 1'b1, 1'b0, 4'd7, 3'd2, "R3 code7");
        step(1'b1, 1'b1, 1'b0, 4'd14, 3'd3, "R3 code14");
        step(1'b1, 1'b1, 1'b0, 4'd15, 3'd4, "R3 code15");
        check(sw_en, snap, "R3 holes unchanged");

        step(1'b0, 1'b0, 1'b0, 4'd3, 3'd5, "R6");
        step(1'b1, 1'b1, 1'b0, 4'd3, 3'd5, "R5 follow 1");
        step(1'b1, 1'b0, 1'b0, 4'd3, 3'd5, "R5 follow 0");
        step(1'b1, 1'b1, 1'b0, 4'd3, 3'd5, "R5 follow 1 again");
        step(1'b0, 1'b0, 1'b0, 4'd3, 3'd5, "R6 kept after fall");
        check(96'(sw_en[5*12+3]), 96'h1, "R6 last value");

        step(1'b1, 1'b1, 1'b1, 4'd2, 3'd2, "R8 strobe under reset");
        step(1'b1, 1'b1, 1'b1, 4'd9, 3'd6, "R8 strobe under reset");
        check(sw_en, '0, "R1 cleared");
        step(1'b0, 1'b0, 1'b0, 4'd0, 3'd0, "R1 release");

        for (int k = 0; k < 16; k++) begin
            step(1'b1, 1'b1, 1'b0, 4'(k), 3'd2, "R9 column fill");
        end
        step(1'b0, 1'b0, 1'b0, 4'd0, 3'd0, "R9");
        check(96'($countones(sw_en)), 96'd12, "R9 twelve on");
        for (int c = 0; c < 8; c++) begin
            step(1'b1, 1'b1, 1'b0, 4'd10, 3'(c), "R9 row fill");
        end
        check(96'($countones(sw_en)), 96'd19, "R9 row and column on");

        for (int n = 0; n < 600; n++) begin
            logic s, d, r;
            s = ($urandom % 3) != 0;
            d = $urandom % 2;
            r = ($urandom % 60) == 0;
            step(s, d, r, 4'($urandom), 3'($urandom), "R7 random");
        end

        step(1'b0, 1'b0, 1'b1, 4'd0, 3'd0, "R1 final reset");
        done = 1'b1;
        summary();
        $finish;
    end
endmodule